// File: doc/BRIEF.md
# Search-Engine SRAM Read Sequencer

This block sits on the device side of a shared command/data bus and turns a two-cycle SRAM read command from a host into a read cycle on an external SRAM. The block compares each command against a read opcode, a two-bit address-type tag and its own device identifier. When a command matches in two consecutive cycles, the block follows a fixed seven-cycle timeline. In that timeline it takes over the shared data bus after a two-cycle turnaround, drives a completion handshake and puts the assembled SRAM address and strobes on the memory side. It then releases everything, so that the host can issue the next command in the cycle right after the timeline ends.

Each tri-stated pin is modelled as a value, an output enable and, for the shared data bus, a separate input. While an enable is low, the matching value outputs rest at fixed idle levels. The bench can therefore compare every port in every cycle. The address is built from two places. The top bits come from a command field, and the low bits come from the data bus, both taken in the first command cycle.

Top module: `srch_sram_rd_seq`

## Requirements
- R1: When reset is asserted (synchronous, active high), every output enable drops to 0 at the next clock edge. With an enable at 0, the matching value outputs rest at idle levels: data bus and SRAM address all zeros, handshake 0, and all three strobes 1.
- R2: A command cycle matches only when all of the following hold: `cmd_valid` is 1, `cmd_in[1:0]` equals `READ_OPC` (default 2'b01), `bus_in[20:19]` is 2'b10 and `bus_in[25:21]` equals `dev_id`. All other bits are ignored. A read starts only when a matching cycle seen while idle (cycle 1A) is followed at once by a second matching cycle (cycle 1B).
- R3: In cycles 2 and 3, which are the two cycles after 1B, every output enable stays 0.
- R4: In cycles 4, 5 and 6, `bus_oe` is 1 and `bus_out` carries the assembled SRAM address, zero-extended to the bus width.
- R5: `hs_oe` is 1 in cycles 5, 6 and 7. `hs_out` is 0 in cycle 5, 1 in cycle 6 and 0 in cycle 7.
- R6: In cycle 6 only, `mem_addr_oe` and `strobe_oe` are 1, with `mem_sel_n`=0, `mem_latch_n`=0 and `mem_wr_n`=1.
- R7: The SRAM address is assembled from cycle 1A only, as follows. Bits [23:21] come from `cmd_in[8:6]`. Bits [20:19] are 0. Bits [18:0] come from `bus_in[18:0]`.
- R8: In cycle 7, `bus_oe`, `strobe_oe` and `mem_addr_oe` are 0. After cycle 7 every enable is 0, and a matching cycle in the very next clock is taken as a new 1A.
- R9: Command cycles presented during cycles 2 to 7 are ignored. They change neither the outputs nor the timeline.
- R10: A cycle 1A that is not followed by a matching 1B leaves all enables at 0. The failing cycle is not taken as a new 1A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | 5 | This device's identifier |
| cmd_valid | input | 1 | Command qualifier from the host |
| cmd_in | input | 11 | Command field from the host |
| bus_in | input | 72 | Shared data bus as seen by the device |
| bus_out | output | 72 | Value the device drives on the shared bus |
| bus_oe | output | 1 | Enable for bus_out |
| hs_out | output | 1 | Completion handshake value |
| hs_oe | output | 1 | Enable for the handshake |
| mem_addr | output | 24 | SRAM address |
| mem_addr_oe | output | 1 | Enable for mem_addr |
| mem_sel_n | output | 1 | SRAM chip select, active low |
| mem_wr_n | output | 1 | SRAM write strobe, active low |
| mem_latch_n | output | 1 | SRAM address latch strobe, active low |
| strobe_oe | output | 1 | Shared enable for the three strobes |

## Verification
A wrong phase in the timeline shows up at the ports within one cycle. Examples are a skipped turnaround cycle or a sequence restarted by a command arriving while busy. An enable then rises or falls one cycle off, and the per-clock reference comparison flags it in that same cycle. A wrong captured address stays hidden until cycle 4, the first cycle in which the device drives the bus. It then appears on `bus_out` and again on `mem_addr` in cycle 6. For that reason the bench gives the second command cycle different address fields from the first. A decode that accepts a bad tag, ID or opcode produces an enable where none is expected about three cycles later.

// File: rtl/srs_pkg.sv
package srs_pkg;
   // One state per timeline step; PH_1B waits for the second command cycle.
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_1B   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_D4   = 3'd4,
      PH_D5   = 3'd5,
      PH_D6   = 3'd6,
      PH_D7   = 3'd7
   } seq_ph_t;
endpackage

// File: rtl/srs_match.sv
// Combinational decode of one command cycle against opcode, tag and ID.
module srs_match #(
   parameter int               OPC_W    = 2,
   parameter int               ID_W     = 5,
   parameter logic [OPC_W-1:0] READ_OPC = 2'b01,
   parameter logic [1:0]       TAG_SRAM = 2'b10
) (
   input  logic             valid_i,
   input  logic [OPC_W-1:0] opc_i,
   input  logic [1:0]       tag_i,
   input  logic [ID_W-1:0]  id_i,
   input  logic [ID_W-1:0]  own_id_i,
   output logic             hit_o
);
   logic opc_ok, tag_ok, id_ok;

   always_comb begin
      opc_ok = (opc_i == READ_OPC);
      tag_ok = (tag_i == TAG_SRAM);
      id_ok  = (id_i == own_id_i);
      hit_o  = valid_i && opc_ok && tag_ok && id_ok;
   end
endmodule

// File: rtl/srs_addr.sv
// Captures and assembles the SRAM address from the first command cycle.
module srs_addr #(
   parameter int ADDR_W = 24,
   parameter int HI_W   = 3,
   parameter int LO_W   = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture_i,
   input  logic [HI_W-1:0]   hi_i,
   input  logic [LO_W-1:0]   lo_i,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int PAD_W = ADDR_W - HI_W - LO_W;

   logic [ADDR_W-1:0] asm_addr;

   generate
      if (PAD_W > 0) begin : g_pad
         assign asm_addr = {hi_i, {PAD_W{1'b0}}, lo_i};
      end else begin : g_tight
         assign asm_addr = {hi_i, lo_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (capture_i) begin
         addr_q <= asm_addr;
      end
   end
endmodule

// File: rtl/srs_timeline.sv
// Seven-step timeline controller.
module srs_timeline
   import srs_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    hit_i,
   output seq_ph_t ph_q,
   output logic    capture_o
);
   seq_ph_t ph_d;

   always_comb begin
      ph_d      = ph_q;
      capture_o = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (hit_i) begin
               ph_d      = PH_1B;
               capture_o = 1'b1;
            end
         end
         PH_1B:   ph_d = hit_i ? PH_T2 : PH_IDLE;
         PH_T2:   ph_d = PH_T3;
         PH_T3:   ph_d = PH_D4;
         PH_D4:   ph_d = PH_D5;
         PH_D5:   ph_d = PH_D6;
         PH_D6:   ph_d = PH_D7;
         PH_D7:   ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ph_q <= PH_IDLE;
      else     ph_q <= ph_d;
   end

   // R10: a failed second cycle ends in idle, never in a fresh 1B wait
   p_abort_to_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_1B && !hit_i) |=> (ph_q == PH_IDLE));

   // R9: once turnaround starts the timeline advances every cycle
   p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
      (ph_q == PH_T2) |=> (ph_q == PH_T3));
endmodule

// File: rtl/srs_drive.sv
// Maps the timeline step to pin values and enables.
module srs_drive
   import srs_pkg::*;
#(
   parameter int BUS_W  = 72,
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  seq_ph_t           ph_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              hs_out,
   output logic              hs_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_addr_oe,
   output logic              mem_sel_n,
   output logic              mem_wr_n,
   output logic              mem_latch_n,
   output logic              strobe_oe
);
   logic [BUS_W-1:0] addr_wide;

   generate
      if (BUS_W > ADDR_W) begin : g_ext
         assign addr_wide = {{(BUS_W-ADDR_W){1'b0}}, addr_i};
      end else begin : g_same
         assign addr_wide = addr_i;
      end
   endgenerate

   always_comb begin
      bus_oe      = (ph_i == PH_D4) || (ph_i == PH_D5) || (ph_i == PH_D6);
      hs_oe       = (ph_i == PH_D5) || (ph_i == PH_D6) || (ph_i == PH_D7);
      hs_out      = (ph_i == PH_D6);
      mem_addr_oe = (ph_i == PH_D6);
      strobe_oe   = (ph_i == PH_D6);
      bus_out     = bus_oe ? addr_wide : '0;
      mem_addr    = mem_addr_oe ? addr_i : '0;
      mem_sel_n   = !strobe_oe;
      mem_latch_n = !strobe_oe;
      mem_wr_n    = 1'b1;
   end

   // R8: the strobe cycle is followed by handshake-only cycle 7
   p_strobe_then_release_r8: assert property (@(posedge clk) disable iff (rst)
      strobe_oe |=> (!strobe_oe && !bus_oe && hs_oe && !hs_out));

   // R6: the write strobe never goes active
   p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
      mem_wr_n);
endmodule

// File: rtl/srch_sram_rd_seq.sv
module srch_sram_rd_seq
   import srs_pkg::*;
#(
   parameter int               BUS_W    = 72,
   parameter int               CMD_W    = 11,
   parameter int               ADDR_W   = 24,
   parameter int               ID_W     = 5,
   parameter int               ID_LSB   = 21,
   parameter int               TAG_LSB  = 19,
   parameter int               HI_LSB   = 6,
   parameter int               HI_W     = 3,
   parameter int               OPC_W    = 2,
   parameter logic [OPC_W-1:0] READ_OPC = 2'b01
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   dev_id,
   input  logic              cmd_valid,
   input  logic [CMD_W-1:0]  cmd_in,
   input  logic [BUS_W-1:0]  bus_in,
   output logic [BUS_W-1:0]  bus_out,
   output logic              bus_oe,
   output logic              hs_out,
   output logic              hs_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_addr_oe,
   output logic              mem_sel_n,
   output logic              mem_wr_n,
   output logic              mem_latch_n,
   output logic              strobe_oe
);
   localparam int          LO_W     = TAG_LSB;
   localparam logic [1:0]  TAG_SRAM = 2'b10;

   // Elaboration-time parameter checks
   generate
      if (ID_LSB < TAG_LSB + 2) begin : g_chk_fields
         $error("ID field overlaps the address-type tag");
      end
      if (ID_LSB + ID_W > BUS_W) begin : g_chk_id
         $error("ID field exceeds bus width");
      end
      if (ADDR_W < HI_W + LO_W || ADDR_W > BUS_W) begin : g_chk_addr
         $error("address width does not fit its sources");
      end
      if (HI_LSB + HI_W > CMD_W || OPC_W > HI_LSB) begin : g_chk_cmd
         $error("command field layout is inconsistent");
      end
   endgenerate

   logic    hit;
   logic    capture;
   seq_ph_t ph;
   logic [ADDR_W-1:0] addr_q;
   logic    unused_bits;

   assign unused_bits = ^{bus_in, cmd_in};

   srs_match #(
      .OPC_W(OPC_W), .ID_W(ID_W), .READ_OPC(READ_OPC), .TAG_SRAM(TAG_SRAM)
   ) u_match (
      .valid_i (cmd_valid),
      .opc_i   (cmd_in[OPC_W-1:0]),
      .tag_i   (bus_in[TAG_LSB +: 2]),
      .id_i    (bus_in[ID_LSB +: ID_W]),
      .own_id_i(dev_id),
      .hit_o   (hit)
   );

   srs_timeline u_tl (
      .clk      (clk),
      .rst      (rst),
      .hit_i    (hit),
      .ph_q     (ph),
      .capture_o(capture)
   );

   srs_addr #(
      .ADDR_W(ADDR_W), .HI_W(HI_W), .LO_W(LO_W)
   ) u_addr (
      .clk      (clk),
      .rst      (rst),
      .capture_i(capture),
      .hi_i     (cmd_in[HI_LSB +: HI_W]),
      .lo_i     (bus_in[LO_W-1:0]),
      .addr_q   (addr_q)
   );

   srs_drive #(
      .BUS_W(BUS_W), .ADDR_W(ADDR_W)
   ) u_drive (
      .clk        (clk),
      .rst        (rst),
      .ph_i       (ph),
      .addr_i     (addr_q),
      .bus_out    (bus_out),
      .bus_oe     (bus_oe),
      .hs_out     (hs_out),
      .hs_oe      (hs_oe),
      .mem_addr   (mem_addr),
      .mem_addr_oe(mem_addr_oe),
      .mem_sel_n  (mem_sel_n),
      .mem_wr_n   (mem_wr_n),
      .mem_latch_n(mem_latch_n),
      .strobe_oe  (strobe_oe)
   );

   // R3: the device claims the bus only after two quiet cycles following 1A/1B
   p_bus_after_turn_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_oe) |-> ($past(cmd_valid, 3) && $past(cmd_valid, 4)));

   // R5: handshake goes high only after a low cycle under enable
   p_hs_low_first_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_out) |-> (hs_oe && $past(hs_oe) && !$past(hs_out)));

   // R5: a high handshake is followed by a driven low one
   p_hs_low_after_r5: assert property (@(posedge clk) disable iff (rst)
      (hs_oe && hs_out) |=> (hs_oe && !hs_out));

   // R7: upper address bits come from the command field of cycle 1A
   p_addr_hi_r7: assert property (@(posedge clk) disable iff (rst)
      mem_addr_oe |-> (mem_addr[ADDR_W-1 -: HI_W] == $past(cmd_in[HI_LSB +: HI_W], 6)));

   // R8: when the handshake is released nothing else is still driven
   p_release_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(hs_oe) |-> (!bus_oe && !strobe_oe && !mem_addr_oe));
endmodule

// File: tb/tb_srch_sram_rd_seq.sv
module tb_srch_sram_rd_seq;
   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  dev_id;
   logic        cmd_valid;
   logic [10:0] cmd_in;
   logic [71:0] bus_in;
   logic [71:0] bus_out;
   logic        bus_oe, hs_out, hs_oe;
   logic [23:0] mem_addr;
   logic        mem_addr_oe, mem_sel_n, mem_wr_n, mem_latch_n, strobe_oe;

   int    total = 0;
   int    bad   = 0;
   bit    finished = 0;
   string scen = "R1";

   // reference model state
   int          step_m = 0;
   logic [23:0] addr_m = '0;

   always #4 clk = ~clk;

   srch_sram_rd_seq dut (
      .clk(clk), .rst(rst), .dev_id(dev_id), .cmd_valid(cmd_valid),
      .cmd_in(cmd_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .hs_out(hs_out), .hs_oe(hs_oe), .mem_addr(mem_addr),
      .mem_addr_oe(mem_addr_oe), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
      .mem_latch_n(mem_latch_n), .strobe_oe(strobe_oe)
   );

   function automatic bit cyc_ok();
      return cmd_valid && cmd_in[1:0] == 2'b01 && bus_in[20:19] == 2'b10
             && bus_in[25:21] == dev_id;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         step_m = 0;
      end else if (step_m == 0) begin
         if (cyc_ok()) begin
            step_m = 1;
            addr_m = {cmd_in[8:6], 2'b00, bus_in[18:0]};
         end
      end else if (step_m == 1) begin
         step_m = cyc_ok() ? 2 : 0;
      end else if (step_m == 7) begin
         step_m = 0;
      end else begin
         step_m = step_m + 1;
      end
   end

   task automatic chk(string what, logic [71:0] act, logic [71:0] exp);
      string tag;
      case (step_m)
         0, 1:    tag = "R2";
         2, 3:    tag = "R3";
         4:       tag = "R4";
         5:       tag = "R5";
         6:       tag = "R6";
         default: tag = "R8";
      endcase
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s (scenario %s) step=%0d %s act=%h exp=%h",
                  tag, scen, step_m, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         logic b_en, h_en, s6;
         b_en = (step_m >= 4 && step_m <= 6);
         h_en = (step_m >= 5 && step_m <= 7);
         s6   = (step_m == 6);
         chk("bus_oe", 72'(bus_oe), 72'(b_en));
         chk("bus_out", bus_out, b_en ? 72'(addr_m) : 72'h0);
         chk("hs_oe", 72'(hs_oe), 72'(h_en));
         chk("hs_out", 72'(hs_out), 72'(s6));
         chk("mem_addr_oe", 72'(mem_addr_oe), 72'(s6));
         chk("strobe_oe", 72'(strobe_oe), 72'(s6));
         chk("mem_sel_n", 72'(mem_sel_n), 72'(!s6));
         chk("mem_latch_n", 72'(mem_latch_n), 72'(!s6));
         chk("mem_wr_n", 72'(mem_wr_n), 72'h1);
         // R7: address on the memory side
         chk("mem_addr R7", 72'(mem_addr), s6 ? 72'(addr_m) : 72'h0);
      end
   end

   task automatic put(bit v, logic [1:0] opc, logic [4:0] id, logic [1:0] tag,
                      logic [2:0] hi, logic [18:0] lo);
      @(posedge clk);
      #1;
      cmd_valid = v;
      cmd_in    = {2'b11, hi, 4'b1010, opc};
      bus_in    = {46'h2AAA_5555_1234, id, tag, lo};
   endtask

   task automatic quiet(int n);
      for (int i = 0; i < n; i++) put(1'b0, 2'b00, 5'd0, 2'b00, 3'd0, 19'd0);
   endtask

   task automatic good_a(logic [2:0] hi, logic [18:0] lo);
      put(1'b1, 2'b01, 5'd9, 2'b10, hi, lo);
   endtask

   initial begin
      rst = 1'b1; dev_id = 5'd9; cmd_valid = 1'b0; cmd_in = '0; bus_in = '0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      scen = "R1"; quiet(3);
      // R2 R4 R5 R6 R7: plain read; 1B carries different address fields
      scen = "R7"; good_a(3'd5, 19'h4_1234); good_a(3'd2, 19'h7_0F0F); quiet(6);
      // R8: back-to-back reads
      scen = "R8"; good_a(3'd7, 19'h7_FFFF); good_a(3'd7, 19'h7_FFFF); quiet(6);
      good_a(3'd0, 19'h0_0001); good_a(3'd0, 19'h0_0001); quiet(7);
      // R2: wrong ID, wrong opcode, wrong tag, invalid
      scen = "R2";
      put(1'b1, 2'b01, 5'd8, 2'b10, 3'd1, 19'h1); put(1'b1, 2'b01, 5'd8, 2'b10, 3'd1, 19'h1);
      quiet(2);
      put(1'b1, 2'b11, 5'd9, 2'b10, 3'd1, 19'h1); put(1'b1, 2'b11, 5'd9, 2'b10, 3'd1, 19'h1);
      quiet(2);
      put(1'b1, 2'b01, 5'd9, 2'b01, 3'd1, 19'h1); put(1'b1, 2'b01, 5'd9, 2'b01, 3'd1, 19'h1);
      quiet(2);
      put(1'b0, 2'b01, 5'd9, 2'b10, 3'd1, 19'h1); put(1'b0, 2'b01, 5'd9, 2'b10, 3'd1, 19'h1);
      quiet(5);
      // R10: good 1A, bad 1B, then a good pair
      scen = "R10";
      good_a(3'd3, 19'h3_3333); put(1'b1, 2'b01, 5'd9, 2'b11, 3'd3, 19'h3_3333);
      quiet(4);
      good_a(3'd4, 19'h2_2222); put(1'b0, 2'b01, 5'd9, 2'b10, 3'd4, 19'h2_2222);
      good_a(3'd6, 19'h1_5A5A); good_a(3'd6, 19'h1_5A5A); quiet(7);
      // R9: matching commands while busy are ignored
      scen = "R9";
      good_a(3'd1, 19'h0_ABCD); good_a(3'd1, 19'h0_ABCD);
      for (int i = 0; i < 6; i++) good_a(3'd6, 19'h6_6666);
      quiet(8);
      // R1: reset in the middle of a sequence
      scen = "R1";
      good_a(3'd2, 19'h5_0505); good_a(3'd2, 19'h5_0505); quiet(3);
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      quiet(4);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule